// File: doc/BRIEF.md
# Programmable Horizontal Line Timing Generator

This block times one video line from a pixel clock. A counter steps through the clocks of a line, numbering them from 1 up to a programmable line total, and then starts again at 1. The counter value is compared against three programmable thresholds to produce active-low horizontal blank and horizontal sync. Blank begins on clock 1 of every line. Sync begins at the front-porch threshold and ends at the sync threshold. Blank ends at the blank threshold. A width of n clocks measured from the first blank edge is therefore programmed as n+1.

Two single-clock strobes serve downstream logic. The line-start strobe marks clock 1 and is meant for vertical counting. The half-line strobe marks clock total/2 and is meant for interlaced operation. The line total must be even so that it can be halved. A write of an odd total, or of zero, is refused and raises a configuration error flag.

Writes go to a shadow bank. The shadow values are copied into the working bank only at a line boundary, so a line already in progress always finishes with the settings it started with. All four timing outputs are launched on the falling edge of the clock.

Top module: `hline_timer`

## Requirements
- R1: The line counter takes the values 1, 2, …, lineTotal and then returns to 1, so line-start pulses recur exactly every lineTotal clocks.
- R2: hBlankN is low for the clocks whose count is below blankEnd, which gives (blankEnd−1) clocks starting at count 1. It is high for the rest of the line.
- R3: hSyncN is low for the clocks whose count is at least fpEnd and below syncEnd, which gives (syncEnd−fpEnd) clocks after a front porch of (fpEnd−1) clocks. It is high for the rest of the line.
- R4: lineStart is high for exactly the one clock with count 1. halfLine is high for exactly the one clock with count lineTotal/2.
- R5: hBlankN, hSyncN, lineStart and halfLine change only on the falling clock edge and never across a rising edge.
- R6: A write is accepted when wrEn is high at a rising edge. The address map is 0 = fpEnd, 1 = syncEnd, 2 = blankEnd and 3 = lineTotal. Accepted values govern outputs only from the next count-1 clock onward. The line in progress keeps its old timing and its old length.
- R7: A write of an odd value or of zero to lineTotal is ignored, the previous total is kept, and cfgErr is set. cfgErr is cleared by the next accepted lineTotal write.
- R8: While rstN is low, hBlankN and hSyncN are high and lineStart, halfLine and cfgErr are low. After reset the registers hold fpEnd=3, syncEnd=7, blankEnd=12 and lineTotal=20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select (0 fpEnd, 1 syncEnd, 2 blankEnd, 3 lineTotal) |
| wrData | input | CW (12) | Register write value |
| hBlankN | output | 1 | Horizontal blank, active low |
| hSyncN | output | 1 | Horizontal sync, active low |
| lineStart | output | 1 | One-clock pulse on count 1 |
| halfLine | output | 1 | One-clock pulse on count lineTotal/2 |
| cfgErr | output | 1 | Set by a refused lineTotal write |

## Verification
The assertions check four things on every cycle. The counter stays within 1..lineTotal and returns to 1 after the last count. The working registers never change except at a line boundary. A refused total write leaves the shadow total untouched and sets cfgErr. lineStart never lasts two clocks. The exact positions and widths of blank, sync and the half-line strobe under several register settings can only be shown by the bench's scenarios, which record whole lines and compare them clock by clock. The same holds for the one-line delay of a mid-line reprogramming and for the absence of any output change at a rising edge.

// File: rtl/htg_pkg.sv
package htg_pkg;
  typedef enum logic [1:0] {
    REG_FP    = 2'd0,
    REG_SYNC  = 2'd1,
    REG_BLANK = 2'd2,
    REG_TOTAL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic restart;
    logic commit;
  } ctl_t;
endpackage

// File: rtl/htg_ctrl.sv
module htg_ctrl
  import htg_pkg::*;
#(
  parameter int CW        = 12,
  parameter int DEF_FP    = 3,
  parameter int DEF_SYNC  = 7,
  parameter int DEF_BLANK = 12,
  parameter int DEF_TOTAL = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic [CW-1:0] wrData,
  input  logic [CW-1:0] hCount,
  output ctl_t          ctl,
  output logic [CW-1:0] actFp,
  output logic [CW-1:0] actSync,
  output logic [CW-1:0] actBlank,
  output logic [CW-1:0] actTotal,
  output logic          cfgErr
);
  localparam int NREG = 4;

  function automatic logic [CW-1:0] defVal(input int idx);
    case (idx)
      0:       return CW'(DEF_FP);
      1:       return CW'(DEF_SYNC);
      2:       return CW'(DEF_BLANK);
      default: return CW'(DEF_TOTAL);
    endcase
  endfunction

  logic [CW-1:0] shadow [NREG];
  logic [CW-1:0] active [NREG];
  logic          totalOk;
  logic          totalWr;

  assign totalWr = wrEn && (wrAddr == REG_TOTAL);
  assign totalOk = (wrData[0] == 1'b0) && (wrData != '0);

  // restart when idle after reset or at the last count of a line
  assign ctl.restart = (hCount == '0) || (hCount >= active[NREG-1]);
  assign ctl.commit  = ctl.restart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) shadow[i] <= defVal(i);
      cfgErr <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == REG_TOTAL) begin
        if (totalOk) begin
          shadow[NREG-1] <= wrData;
          cfgErr         <= 1'b0;
        end else begin
          cfgErr <= 1'b1;
        end
      end else begin
        shadow[wrAddr] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) active[i] <= defVal(i);
    end else if (ctl.commit) begin
      for (int i = 0; i < NREG; i++) active[i] <= shadow[i];
    end
  end

  assign actFp    = active[0];
  assign actSync  = active[1];
  assign actBlank = active[2];
  assign actTotal = active[3];

  // R7: a refused total write keeps the old value and raises the flag
  a_r7_reject_odd: assert property (@(posedge clk) disable iff (!rstN)
    (totalWr && (wrData[0] || wrData == '0)) |=> (cfgErr && $stable(shadow[NREG-1])));

  // R6: working registers move only at a line boundary
  a_r6_hold_midline: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.restart |=> ($stable(active[0]) && $stable(active[1]) &&
                      $stable(active[2]) && $stable(active[3])));

  // R7: the working total is always even and nonzero
  a_r7_total_even: assert property (@(posedge clk) disable iff (!rstN)
    (active[NREG-1][0] == 1'b0) && (active[NREG-1] != '0));
endmodule

// File: rtl/htg_dp.sv
module htg_dp
  import htg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_t          ctl,
  input  logic [CW-1:0] actFp,
  input  logic [CW-1:0] actSync,
  input  logic [CW-1:0] actBlank,
  input  logic [CW-1:0] actTotal,
  output logic [CW-1:0] hCount,
  output logic          hBlankN,
  output logic          hSyncN,
  output logic          lineStart,
  output logic          halfLine
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] halfPoint;
  logic          inLine;
  logic          blankNxt;
  logic          syncNxt;
  logic          startNxt;
  logic          halfNxt;

  always_ff @(posedge clk) begin
    if (!rstN)            hCount <= '0;
    else if (ctl.restart) hCount <= ONE;
    else                  hCount <= hCount + ONE;
  end

  always_comb begin
    halfPoint = {1'b0, actTotal[CW-1:1]};
    inLine    = (hCount != '0);
    blankNxt  = inLine && (hCount < actBlank);
    syncNxt   = inLine && (hCount >= actFp) && (hCount < actSync);
    startNxt  = (hCount == ONE);
    halfNxt   = inLine && (hCount == halfPoint);
  end

  // output stage launches on the falling edge
  always_ff @(negedge clk) begin
    if (!rstN) begin
      hBlankN   <= 1'b1;
      hSyncN    <= 1'b1;
      lineStart <= 1'b0;
      halfLine  <= 1'b0;
    end else begin
      hBlankN   <= ~blankNxt;
      hSyncN    <= ~syncNxt;
      lineStart <= startNxt;
      halfLine  <= halfNxt;
    end
  end

  // R1: counter never passes the line total
  a_r1_count_range: assert property (@(posedge clk) disable iff (!rstN)
    (hCount != '0) |-> (hCount <= actTotal));

  // R1: the last count is followed by count 1
  a_r1_wrap_to_one: assert property (@(posedge clk) disable iff (!rstN)
    ((hCount != '0) && (hCount == actTotal)) |=> (hCount == ONE));

  // R4: the line-start strobe lasts one clock
  a_r4_start_single: assert property (@(negedge clk) disable iff (!rstN)
    lineStart |=> !lineStart);
endmodule

// File: rtl/hline_timer.sv
module hline_timer
  import htg_pkg::*;
#(
  parameter int CW        = 12,
  parameter int DEF_FP    = 3,
  parameter int DEF_SYNC  = 7,
  parameter int DEF_BLANK = 12,
  parameter int DEF_TOTAL = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic [CW-1:0] wrData,
  output logic          hBlankN,
  output logic          hSyncN,
  output logic          lineStart,
  output logic          halfLine,
  output logic          cfgErr
);
  ctl_t          ctl;
  logic [CW-1:0] hCount;
  logic [CW-1:0] actFp;
  logic [CW-1:0] actSync;
  logic [CW-1:0] actBlank;
  logic [CW-1:0] actTotal;

  htg_ctrl #(
    .CW(CW), .DEF_FP(DEF_FP), .DEF_SYNC(DEF_SYNC),
    .DEF_BLANK(DEF_BLANK), .DEF_TOTAL(DEF_TOTAL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hCount(hCount), .ctl(ctl), .actFp(actFp), .actSync(actSync),
    .actBlank(actBlank), .actTotal(actTotal), .cfgErr(cfgErr)
  );

  htg_dp #(.CW(CW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .actFp(actFp), .actSync(actSync),
    .actBlank(actBlank), .actTotal(actTotal), .hCount(hCount),
    .hBlankN(hBlankN), .hSyncN(hSyncN), .lineStart(lineStart), .halfLine(halfLine)
  );
endmodule

// File: tb/sim_hline_timer.sv
`timescale 1ns/100ps
module sim_hline_timer;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrAddr = '0;
  logic [CW-1:0] wrData = '0;
  logic          hBlankN, hSyncN, lineStart, halfLine, cfgErr;

  int checks = 0;
  int fails = 0;
  int glitchCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hline_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hBlankN(hBlankN), .hSyncN(hSyncN), .lineStart(lineStart),
    .halfLine(halfLine), .cfgErr(cfgErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance one clock; sample just before and just after the rising edge
  task automatic step();
    logic [3:0] pre;
    @(negedge clk); #2;
    pre = {hBlankN, hSyncN, lineStart, halfLine};
    @(posedge clk); #1;
    if (pre != {hBlankN, hSyncN, lineStart, halfLine}) glitchCnt++;
  endtask

  task automatic wr(input int addr, input int data);
    wrEn = 1'b1; wrAddr = 2'(addr); wrData = CW'(data);
    step();
    wrEn = 1'b0;
  endtask

  task automatic wait_line_start();
    for (int k = 0; k < 400; k++) begin
      step();
      if (lineStart) return;
    end
    check(1'b0, "R1 no line start seen", 0, 1);
  endtask

  // compares counts fromIdx..total, then expects the next line start
  task automatic capture(input int fp, input int sy, input int bl, input int tot,
                         input int fromIdx, input string tag);
    int eBl = 0, eSy = 0, eLs = 0, eHl = 0;
    int g0 = glitchCnt;
    for (int i = fromIdx; i <= tot; i++) begin
      step();
      if (hBlankN   !== !(i < bl))            eBl++;
      if (hSyncN    !== !(i >= fp && i < sy)) eSy++;
      if (lineStart !== (i == 1))             eLs++;
      if (halfLine  !== (i == tot / 2))       eHl++;
    end
    check(eBl == 0, {"R2 blank ", tag}, eBl, 0);
    check(eSy == 0, {"R3 sync ", tag}, eSy, 0);
    check(eLs == 0 && eHl == 0, {"R4 strobes ", tag}, eLs + eHl, 0);
    check(glitchCnt == g0, {"R5 rising-edge change ", tag}, glitchCnt - g0, 0);
    step();
    check(lineStart === 1'b1, {"R1 period ", tag}, int'(lineStart), 1);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (4) step();
    check(hBlankN === 1'b1 && hSyncN === 1'b1, "R8 reset syncs", {hBlankN, hSyncN}, 3);
    check(lineStart === 1'b0 && halfLine === 1'b0 && cfgErr === 1'b0,
          "R8 reset strobes", {lineStart, halfLine, cfgErr}, 0);
    rstN = 1'b1;
  endtask

  task automatic t_default();
    wait_line_start();
    capture(3, 7, 12, 20, 2, "R8 defaults");
    capture(3, 7, 12, 20, 2, "default second line");
  endtask

  task automatic t_reprogram();
    wait_line_start();
    wr(0, 5); wr(1, 11); wr(2, 16); wr(3, 28);
    capture(3, 7, 12, 20, 6, "R6 old line kept");
    capture(5, 11, 16, 28, 2, "R6 new line");
  endtask

  task automatic t_reject();
    wait_line_start();
    wr(3, 27);
    check(cfgErr === 1'b1, "R7 odd total flag", int'(cfgErr), 1);
    wr(3, 0);
    check(cfgErr === 1'b1, "R7 zero total flag", int'(cfgErr), 1);
    capture(5, 11, 16, 28, 4, "R7 total kept");
    wr(3, 28);
    check(cfgErr === 1'b0, "R7 flag cleared", int'(cfgErr), 0);
    capture(5, 11, 16, 28, 3, "R7 after clear");
  endtask

  task automatic t_short();
    wait_line_start();
    wr(0, 1); wr(1, 3); wr(2, 5); wr(3, 6);
    capture(5, 11, 16, 28, 6, "R6 before short");
    capture(1, 3, 5, 6, 2, "R3 zero porch");
    capture(1, 3, 5, 6, 2, "R4 short line");
  endtask

  initial begin
    t_reset();
    t_default();
    t_reprogram();
    t_reject();
    t_short();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule